// File: doc/BRIEF.md
# Flash Command and Lock Controller

This block stands between a 32-bit register port and a behavioural model of an on-chip flash array. Software loads a page buffer, then writes a command word. The command word carries a protection keyword, an operation code and a 16-bit argument. The controller decodes the word and checks the keyword and the argument. It then checks the target range against per-region lock bits. After that it walks the array one word per cycle to erase or program it, and it holds a fixed settle period before it reports ready again. Commands that return data put their words in a result register. Software reads that register one word at a time.

Programming follows flash rules: a program cycle can only clear bits, so a stored word becomes the old word AND the buffer word. Erasing sets bits back to one. Erasing is offered for the whole array, one plane, one sector or a group of pages. There is also a combined erase-then-program page command. The controller keeps 256 lock bits and a small set of general-purpose non-volatile bits. Both sets are changed and read through the same command port. A descriptor command returns eight words that describe the organization of the array, so driver code does not need fixed sizes.

The sequencer has four states. ST_IDLE is ready and accepting commands. ST_ERASE writes ones over a word range. ST_PROG ANDs buffer words into one page. ST_SETTLE counts the busy delay. Its transitions are:
- ST_IDLE to ST_ERASE on an accepted erase or erase-program command.
- ST_IDLE to ST_PROG on an accepted plain page write.
- ST_IDLE to ST_SETTLE on a lock, bit, readback or descriptor command, or on a lock-violation abort.
- ST_ERASE to ST_PROG at the end of the range for erase-program.
- ST_ERASE to ST_SETTLE at the end of the range otherwise.
- ST_PROG to ST_SETTLE after the last page word.
- ST_SETTLE to ST_IDLE when the counter reaches zero.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: The register map is: command at address 0, status at address 1, result at address 2, and page-buffer word i at address 8+i. The command word is laid out as bits [31:24] keyword, [23:8] argument, [7:0] code. A command write is accepted only when the keyword is 0xC3. A write with any other keyword changes nothing except that it sets the command-error flag.
- R2: From the cycle after acceptance until the operation completes, the ready flag is 0. Command and page-buffer writes made during that time are ignored.
- R3: The interrupt output is high for exactly one cycle each time the ready flag rises. It is never high in any other cycle.
- R4: Write-page (code 0x01, argument = page) replaces each word of that page with the old word AND the buffer word.
- R5: Erase-write-page (code 0x03, argument = page) sets the page to all ones and then programs it, so the page ends equal to the buffer.
- R6: These erase commands set every word of their range to 0xFFFFFFFF and leave other pages untouched:
  - whole array (code 0x05);
  - plane (code 0x06, argument = plane, 128 pages per plane);
  - sector (code 0x07, argument = sector, 16 pages per sector);
  - page group (code 0x08, argument = page, range = 4 pages starting at the argument rounded down to a multiple of 4).
- R7: A write or erase whose range includes any page in a locked region is aborted. The array is not changed, the lock-error flag is set, and ready still returns high with one interrupt.
- R8: Set-lock (0x10) and clear-lock (0x11) change one lock bit, selected by the argument, with one region per page. Get-lock (0x12, argument = k) loads the result register with lock bits 32k+31 down to 32k.
- R9: Set-bit (0x20) and clear-bit (0x21) change one of 4 general-purpose bits. Get-bits (0x22) loads the result register with those bits in [3:0].
- R10: The descriptor command (0x00) makes successive result reads return 4096, 16, 256, 2, 128, 256, 1, 16. These are total bytes, page bytes, page count, planes, pages per plane, lock regions, pages per region and pages per sector. Every later read returns 0.
- R11: A command with the correct keyword but an unknown code or an out-of-range argument is not started. It sets the command-error flag, and ready stays high with no interrupt.
- R12: The status register reads bit 0 = ready, bit 1 = command error, bit 2 = lock error. Each accepted command clears both error flags, and an aborted command sets the lock error again.
- R13: After reset, ready is 1, both error flags are 0, the interrupt is 0, all lock and general-purpose bits are 0, and every array word is 0xFFFFFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_waddr | input | 4 | Register write address |
| reg_wdata | input | 32 | Register write data |
| reg_rd | input | 1 | Register read strobe (advances the result register) |
| reg_raddr | input | 4 | Register read address |
| reg_rdata | output | 32 | Register read data, combinational |
| arr_raddr | input | 10 | Array model word read address |
| arr_rdata | output | 32 | Array model word read data |
| irq | output | 1 | One-cycle pulse on the rise of ready |

## Verification
Some properties are checked on every cycle:
- the interrupt is a single-cycle pulse that appears only as ready rises;
- ready falls only after a command write that carries the correct keyword;
- the command-error flag rises only after a command write made while ready;
- the lock bits stay fixed while busy;
- no erase or program cycle ever touches a word whose region is locked.

Only the directed scenarios can show the rest:
- the data results: AND-programming, erase-then-program, the exact bounds of each erase granularity, the lock and bit readback words, and the descriptor sequence;
- that commands and buffer writes arriving while busy leave the array unchanged.

// File: rtl/flash_ctrl_pkg.sv
package flash_ctrl_pkg;

    localparam logic [7:0] CMD_KEY = 8'hC3;

    localparam logic [7:0] OP_DESC = 8'h00;
    localparam logic [7:0] OP_WP   = 8'h01;
    localparam logic [7:0] OP_EWP  = 8'h03;
    localparam logic [7:0] OP_EA   = 8'h05;
    localparam logic [7:0] OP_EPL  = 8'h06;
    localparam logic [7:0] OP_ESC  = 8'h07;
    localparam logic [7:0] OP_EGR  = 8'h08;
    localparam logic [7:0] OP_SLK  = 8'h10;
    localparam logic [7:0] OP_CLK  = 8'h11;
    localparam logic [7:0] OP_GLK  = 8'h12;
    localparam logic [7:0] OP_SGP  = 8'h20;
    localparam logic [7:0] OP_CGP  = 8'h21;
    localparam logic [7:0] OP_GGP  = 8'h22;

    localparam logic [3:0] REG_CMD  = 4'd0;
    localparam logic [3:0] REG_STAT = 4'd1;
    localparam logic [3:0] REG_RES  = 4'd2;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ERASE,
        ST_PROG,
        ST_SETTLE
    } seq_state_e;

    typedef enum logic [1:0] {
        RES_NONE,
        RES_DESC,
        RES_ONE
    } res_kind_e;

endpackage

// File: rtl/flash_array_model.sv
module flash_array_model #(
    parameter int WORDS = 1024,
    localparam int AW = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we_erase,
    input  logic          we_prog,
    input  logic [AW-1:0] waddr,
    input  logic [31:0]   wdata,
    input  logic [AW-1:0] raddr,
    output logic [31:0]   rdata
);

    logic [31:0] mem [WORDS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) begin
                mem[i] <= '1;
            end
        end else if (we_erase) begin
            mem[waddr] <= '1;
        end else if (we_prog) begin
            mem[waddr] <= mem[waddr] & wdata;
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/flash_lock_guard.sv
module flash_lock_guard #(
    parameter int NUM_PAGES        = 256,
    parameter int PAGES_PER_REGION = 1,
    parameter int GP_BITS          = 4,
    localparam int PGW     = $clog2(NUM_PAGES),
    localparam int REGIONS = NUM_PAGES / PAGES_PER_REGION,
    localparam int RW      = $clog2(REGIONS),
    localparam int LSW     = $clog2(REGIONS / 32),
    localparam int GW      = $clog2(GP_BITS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               set_lock,
    input  logic               clr_lock,
    input  logic [RW-1:0]      lock_idx,
    input  logic               set_gp,
    input  logic               clr_gp,
    input  logic [GW-1:0]      gp_idx,
    input  logic [PGW-1:0]     first_page,
    input  logic [PGW-1:0]     last_page,
    input  logic [LSW-1:0]     word_sel,
    output logic               range_locked,
    output logic [31:0]        lock_word,
    output logic [GP_BITS-1:0] gp_bits,
    output logic [REGIONS-1:0] lock_vec
);

    localparam int RSH = $clog2(PAGES_PER_REGION);

    logic [RW-1:0]      first_reg;
    logic [RW-1:0]      last_reg;
    logic [REGIONS-1:0] hit;

    assign first_reg = RW'(first_page >> RSH);
    assign last_reg  = RW'(last_page >> RSH);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lock_vec <= '0;
            gp_bits  <= '0;
        end else begin
            if (set_lock) lock_vec[lock_idx] <= 1'b1;
            if (clr_lock) lock_vec[lock_idx] <= 1'b0;
            if (set_gp)   gp_bits[gp_idx]    <= 1'b1;
            if (clr_gp)   gp_bits[gp_idx]    <= 1'b0;
        end
    end

    for (genvar r = 0; r < REGIONS; r++) begin : g_hit
        assign hit[r] = lock_vec[r] && (RW'(r) >= first_reg) && (RW'(r) <= last_reg);
    end

    assign range_locked = |hit;
    assign lock_word    = lock_vec[word_sel*32 +: 32];

endmodule

// File: rtl/flash_result_regs.sv
module flash_result_regs
    import flash_ctrl_pkg::*;
#(
    parameter int NUM_PAGES        = 256,
    parameter int PAGE_WORDS       = 4,
    parameter int PLANES           = 2,
    parameter int SECTOR_PAGES     = 16,
    parameter int PAGES_PER_REGION = 1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        load_desc,
    input  logic        load_single,
    input  logic [31:0] single_word,
    input  logic        pop,
    output logic [31:0] word
);

    localparam int DESC_WORDS = 8;
    localparam int IW         = $clog2(DESC_WORDS + 1);

    res_kind_e   kind;
    logic [IW-1:0] idx;
    logic [IW-1:0] len;
    logic [31:0]   held;

    function automatic logic [31:0] desc_word(input logic [IW-1:0] i);
        case (i)
            IW'(0):  return 32'(NUM_PAGES * PAGE_WORDS * 4);
            IW'(1):  return 32'(PAGE_WORDS * 4);
            IW'(2):  return 32'(NUM_PAGES);
            IW'(3):  return 32'(PLANES);
            IW'(4):  return 32'(NUM_PAGES / PLANES);
            IW'(5):  return 32'(NUM_PAGES / PAGES_PER_REGION);
            IW'(6):  return 32'(PAGES_PER_REGION);
            IW'(7):  return 32'(SECTOR_PAGES);
            default: return 32'd0;
        endcase
    endfunction

    always_comb begin
        unique case (kind)
            RES_DESC: len = IW'(DESC_WORDS);
            RES_ONE:  len = IW'(1);
            default:  len = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kind <= RES_NONE;
            idx  <= '0;
            held <= '0;
        end else if (load_desc) begin
            kind <= RES_DESC;
            idx  <= '0;
        end else if (load_single) begin
            kind <= RES_ONE;
            held <= single_word;
            idx  <= '0;
        end else if (pop && idx < len) begin
            idx <= idx + 1'b1;
        end
    end

    always_comb begin
        if (idx >= len)            word = '0;
        else if (kind == RES_DESC) word = desc_word(idx);
        else                       word = held;
    end

endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
    import flash_ctrl_pkg::*;
#(
    parameter int NUM_PAGES        = 256,
    parameter int PAGE_WORDS       = 4,
    parameter int PLANES           = 2,
    parameter int SECTOR_PAGES     = 16,
    parameter int GROUP_PAGES      = 4,
    parameter int PAGES_PER_REGION = 1,
    parameter int GP_BITS          = 4,
    parameter int BUSY_CYCLES      = 4,
    localparam int WORDS = NUM_PAGES * PAGE_WORDS,
    localparam int AW    = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [3:0]    reg_waddr,
    input  logic [31:0]   reg_wdata,
    input  logic          reg_rd,
    input  logic [3:0]    reg_raddr,
    output logic [31:0]   reg_rdata,
    input  logic [AW-1:0] arr_raddr,
    output logic [31:0]   arr_rdata,
    output logic          irq
);

    localparam int PGW         = $clog2(NUM_PAGES);
    localparam int PWW         = $clog2(PAGE_WORDS);
    localparam int REGIONS     = NUM_PAGES / PAGES_PER_REGION;
    localparam int RW          = $clog2(REGIONS);
    localparam int LSW         = $clog2(REGIONS / 32);
    localparam int GW          = $clog2(GP_BITS);
    localparam int CW          = $clog2(BUSY_CYCLES + 1);
    localparam int PLANE_PAGES = NUM_PAGES / PLANES;
    localparam int SECTORS     = NUM_PAGES / SECTOR_PAGES;
    localparam int GSH         = $clog2(GROUP_PAGES);

    seq_state_e state, state_nx;

    logic [7:0]         op_r;
    logic [AW-1:0]      first_w, last_w, cur_w;
    logic [CW-1:0]      cnt;
    logic               cmd_err, lock_err;
    logic               ready, ready_q;
    logic [31:0]        pbuf [PAGE_WORDS];

    logic               cmd_wr, key_ok, code_ok, arg_ok, rng_op, ers_op;
    logic               accept, reject, abort;
    logic [7:0]         code;
    logic [31:0]        arg32, f32, l32;
    logic [PGW-1:0]     first_page, last_page;

    logic               range_locked;
    logic [31:0]        lock_word;
    logic [GP_BITS-1:0] gp_bits;
    logic [REGIONS-1:0] lock_vec;
    logic [31:0]        res_word;
    logic               arr_erase, arr_prog;
    logic [AW-1:0]      arr_waddr;
    logic [31:0]        arr_wdata;

    // ---------------- command decode ----------------
    always_comb begin
        code    = reg_wdata[7:0];
        arg32   = {16'd0, reg_wdata[23:8]};
        code_ok = 1'b1;
        arg_ok  = 1'b1;
        rng_op  = 1'b0;
        ers_op  = 1'b0;
        f32     = '0;
        l32     = '0;
        case (code)
            OP_WP, OP_EWP: begin
                rng_op = 1'b1;
                ers_op = (code == OP_EWP);
                arg_ok = arg32 < 32'(NUM_PAGES);
                f32    = arg32;
                l32    = arg32;
            end
            OP_EA: begin
                rng_op = 1'b1;
                ers_op = 1'b1;
                l32    = 32'(NUM_PAGES - 1);
            end
            OP_EPL: begin
                rng_op = 1'b1;
                ers_op = 1'b1;
                arg_ok = arg32 < 32'(PLANES);
                f32    = arg32 * 32'(PLANE_PAGES);
                l32    = f32 + 32'(PLANE_PAGES - 1);
            end
            OP_ESC: begin
                rng_op = 1'b1;
                ers_op = 1'b1;
                arg_ok = arg32 < 32'(SECTORS);
                f32    = arg32 * 32'(SECTOR_PAGES);
                l32    = f32 + 32'(SECTOR_PAGES - 1);
            end
            OP_EGR: begin
                rng_op = 1'b1;
                ers_op = 1'b1;
                arg_ok = arg32 < 32'(NUM_PAGES);
                f32    = (arg32 >> GSH) << GSH;
                l32    = f32 + 32'(GROUP_PAGES - 1);
            end
            OP_SLK, OP_CLK: arg_ok = arg32 < 32'(REGIONS);
            OP_GLK:         arg_ok = arg32 < 32'(REGIONS / 32);
            OP_SGP, OP_CGP: arg_ok = arg32 < 32'(GP_BITS);
            OP_DESC, OP_GGP: ;
            default: code_ok = 1'b0;
        endcase
    end

    assign first_page = f32[PGW-1:0];
    assign last_page  = l32[PGW-1:0];
    assign cmd_wr     = reg_wr && (reg_waddr == REG_CMD);
    assign key_ok     = (reg_wdata[31:24] == CMD_KEY);
    assign accept     = ready && cmd_wr && key_ok && code_ok && arg_ok;
    assign reject     = ready && cmd_wr && !(key_ok && code_ok && arg_ok);
    assign abort      = accept && rng_op && range_locked;

    // ---------------- sequencer: state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // ---------------- sequencer: next state ----------------
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (accept) begin
                    if (abort)       state_nx = ST_SETTLE;
                    else if (ers_op) state_nx = ST_ERASE;
                    else if (rng_op) state_nx = ST_PROG;
                    else             state_nx = ST_SETTLE;
                end
            end
            ST_ERASE: begin
                if (cur_w == last_w) state_nx = (op_r == OP_EWP) ? ST_PROG : ST_SETTLE;
            end
            ST_PROG: begin
                if (cur_w == last_w) state_nx = ST_SETTLE;
            end
            ST_SETTLE: begin
                if (cnt == '0) state_nx = ST_IDLE;
            end
        endcase
    end

    // ---------------- sequencer datapath ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_r     <= '0;
            first_w  <= '0;
            last_w   <= '0;
            cur_w    <= '0;
            cnt      <= '0;
            cmd_err  <= 1'b0;
            lock_err <= 1'b0;
            ready_q  <= 1'b1;
        end else begin
            ready_q <= ready;
            if (reject) cmd_err <= 1'b1;
            if (accept) begin
                op_r     <= code;
                first_w  <= {first_page, {PWW{1'b0}}};
                last_w   <= {last_page, {PWW{1'b1}}};
                cur_w    <= {first_page, {PWW{1'b0}}};
                cnt      <= CW'(BUSY_CYCLES - 1);
                cmd_err  <= 1'b0;
                lock_err <= abort;
            end
            if (state == ST_ERASE) begin
                cur_w <= (cur_w == last_w) ? first_w : cur_w + 1'b1;
            end
            if (state == ST_PROG) begin
                cur_w <= cur_w + 1'b1;
            end
            if (state == ST_SETTLE && cnt != '0) begin
                cnt <= cnt - 1'b1;
            end
        end
    end

    // ---------------- page buffer ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < PAGE_WORDS; i++) pbuf[i] <= '1;
        end else if (ready && reg_wr && reg_waddr[3]) begin
            pbuf[reg_waddr[PWW-1:0]] <= reg_wdata;
        end
    end

    // ---------------- outputs ----------------
    always_comb begin
        ready     = (state == ST_IDLE);
        irq       = ready && !ready_q;
        arr_erase = (state == ST_ERASE);
        arr_prog  = (state == ST_PROG);
        arr_waddr = cur_w;
        arr_wdata = pbuf[cur_w[PWW-1:0]];
        unique case (reg_raddr)
            REG_STAT: reg_rdata = {29'd0, lock_err, cmd_err, ready};
            REG_RES:  reg_rdata = res_word;
            default:  reg_rdata = '0;
        endcase
    end

    flash_array_model #(.WORDS(WORDS)) u_array (
        .clk      (clk),
        .rst_n    (rst_n),
        .we_erase (arr_erase),
        .we_prog  (arr_prog),
        .waddr    (arr_waddr),
        .wdata    (arr_wdata),
        .raddr    (arr_raddr),
        .rdata    (arr_rdata)
    );

    flash_lock_guard #(
        .NUM_PAGES        (NUM_PAGES),
        .PAGES_PER_REGION (PAGES_PER_REGION),
        .GP_BITS          (GP_BITS)
    ) u_guard (
        .clk          (clk),
        .rst_n        (rst_n),
        .set_lock     (accept && code == OP_SLK),
        .clr_lock     (accept && code == OP_CLK),
        .lock_idx     (arg32[RW-1:0]),
        .set_gp       (accept && code == OP_SGP),
        .clr_gp       (accept && code == OP_CGP),
        .gp_idx       (arg32[GW-1:0]),
        .first_page   (first_page),
        .last_page    (last_page),
        .word_sel     (arg32[LSW-1:0]),
        .range_locked (range_locked),
        .lock_word    (lock_word),
        .gp_bits      (gp_bits),
        .lock_vec     (lock_vec)
    );

    flash_result_regs #(
        .NUM_PAGES        (NUM_PAGES),
        .PAGE_WORDS       (PAGE_WORDS),
        .PLANES           (PLANES),
        .SECTOR_PAGES     (SECTOR_PAGES),
        .PAGES_PER_REGION (PAGES_PER_REGION)
    ) u_result (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_desc   (accept && code == OP_DESC),
        .load_single (accept && (code == OP_GLK || code == OP_GGP)),
        .single_word ((code == OP_GLK) ? lock_word : 32'(gp_bits)),
        .pop         (reg_rd && reg_raddr == REG_RES),
        .word        (res_word)
    );

endmodule

// File: rtl/flash_cmd_ctrl_chk.sv
module flash_cmd_ctrl_chk
    import flash_ctrl_pkg::*;
#(
    parameter int NUM_PAGES        = 256,
    parameter int PAGE_WORDS       = 4,
    parameter int PAGES_PER_REGION = 1,
    localparam int AW      = $clog2(NUM_PAGES * PAGE_WORDS),
    localparam int PWW     = $clog2(PAGE_WORDS),
    localparam int RSH     = $clog2(PAGES_PER_REGION),
    localparam int REGIONS = NUM_PAGES / PAGES_PER_REGION,
    localparam int RW      = $clog2(REGIONS)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               ready,
    input logic               irq,
    input logic               cmd_wr,
    input logic [7:0]         key,
    input logic               cmd_err,
    input logic               arr_erase,
    input logic               arr_prog,
    input logic [AW-1:0]      arr_waddr,
    input logic [REGIONS-1:0] lock_vec
);

    logic [RW-1:0] wr_region;
    assign wr_region = RW'((arr_waddr >> PWW) >> RSH);

    assert_irq_on_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (ready && !$past(ready)));

    assert_irq_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    assert_key_gate_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ready) |-> $past(cmd_wr && key == CMD_KEY));

    assert_err_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmd_err) |-> $past(cmd_wr && ready));

    assert_locks_held_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |=> $stable(lock_vec));

    assert_no_locked_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_erase || arr_prog) |-> !lock_vec[wr_region]);

endmodule

bind flash_cmd_ctrl flash_cmd_ctrl_chk #(
    .NUM_PAGES        (NUM_PAGES),
    .PAGE_WORDS       (PAGE_WORDS),
    .PAGES_PER_REGION (PAGES_PER_REGION)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ready     (ready),
    .irq       (irq),
    .cmd_wr    (cmd_wr),
    .key       (reg_wdata[31:24]),
    .cmd_err   (cmd_err),
    .arr_erase (arr_erase),
    .arr_prog  (arr_prog),
    .arr_waddr (arr_waddr),
    .lock_vec  (lock_vec)
);

// File: tb/test_flash_cmd_ctrl.sv
module test_flash_cmd_ctrl;

    localparam logic [7:0] KEY = 8'hC3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_waddr = '0;
    logic [31:0] reg_wdata = '0;
    logic        reg_rd = 1'b0;
    logic [3:0]  reg_raddr = '0;
    logic [31:0] reg_rdata;
    logic [9:0]  arr_raddr = '0;
    logic [31:0] arr_rdata;
    logic        irq;

    int n_vec = 0;
    int n_bad = 0;
    int irq_cnt = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    flash_cmd_ctrl i_flash_cmd_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_waddr (reg_waddr),
        .reg_wdata (reg_wdata),
        .reg_rd    (reg_rd),
        .reg_raddr (reg_raddr),
        .reg_rdata (reg_rdata),
        .arr_raddr (arr_raddr),
        .arr_rdata (arr_rdata),
        .irq       (irq)
    );

    always @(negedge clk) if (rst_n && irq) irq_cnt++;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_waddr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_raddr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic arr_word(input int addr, output logic [31:0] d);
        arr_raddr = 10'(addr);
        #1 d = arr_rdata;
    endtask

    task automatic cmd(input logic [7:0] code, input int arg, input logic [7:0] key = KEY);
        reg_write(4'd0, {key, 16'(arg), code});
    endtask

    task automatic wait_ready();
        logic [31:0] s;
        s = '0;
        for (int i = 0; i < 3000 && !s[0]; i++) reg_read(4'd1, s);
        if (!s[0]) begin
            n_vec++; n_bad++;
            $display("FAIL R2 ready never returned actual=0 expected=1");
        end
        repeat (2) @(negedge clk);
    endtask

    // run an accepted command and check one interrupt pulse (R3)
    task automatic run(input logic [7:0] code, input int arg);
        int c0;
        c0 = irq_cnt;
        cmd(code, arg);
        wait_ready();
        chk("R3 irq pulses per command", 32'(irq_cnt - c0), 32'd1);
    endtask

    task automatic fill_buf(input logic [31:0] w0, w1, w2, w3);
        reg_write(4'd8, w0); reg_write(4'd9, w1);
        reg_write(4'd10, w2); reg_write(4'd11, w3);
    endtask

    task automatic chk_page(input string req, input int p, input logic [31:0] e0, input logic [31:0] e3);
        logic [31:0] d;
        arr_word(p * 4, d);     chk(req, d, e0);
        arr_word(p * 4 + 3, d); chk(req, d, e3);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        reg_read(4'd1, d);
        chk("R13 status after reset", d, 32'd1);
        chk("R13 irq after reset", {31'd0, irq}, 32'd0);
        chk_page("R13 array erased after reset", 0, 32'hFFFFFFFF, 32'hFFFFFFFF);
        chk_page("R13 array erased after reset", 255, 32'hFFFFFFFF, 32'hFFFFFFFF);
    endtask

    task automatic t_keyword();
        logic [31:0] d;
        int c0;
        fill_buf(32'h0, 32'h0, 32'h0, 32'h0);
        c0 = irq_cnt;
        cmd(8'h01, 2, 8'h3C);
        repeat (3) @(negedge clk);
        reg_read(4'd1, d);
        chk("R1 bad key sets command error", d, 32'd3);
        chk("R1 bad key no irq", 32'(irq_cnt - c0), 32'd0);
        chk_page("R1 bad key leaves page", 2, 32'hFFFFFFFF, 32'hFFFFFFFF);
        run(8'h22, 0);
        reg_read(4'd1, d);
        chk("R12 accepted command clears errors", d, 32'd1);
    endtask

    task automatic t_write_page();
        fill_buf(32'hF0F0_1234, 32'h0, 32'hAAAA_5555, 32'h1357_9BDF);
        run(8'h01, 5);
        chk_page("R4 first program", 5, 32'hF0F0_1234, 32'h1357_9BDF);
        fill_buf(32'h0FF0_FF00, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_0000);
        run(8'h01, 5);
        chk_page("R4 program ANDs into page", 5, 32'h00F0_1200, 32'h1357_0000);
    endtask

    task automatic t_erase_write();
        fill_buf(32'hCAFE_F00D, 32'h1, 32'h2, 32'hBEEF_0001);
        run(8'h03, 5);
        chk_page("R5 erase then program", 5, 32'hCAFE_F00D, 32'hBEEF_0001);
    endtask

    task automatic zero_pages(input int a, input int b);
        fill_buf(32'h0, 32'h0, 32'h0, 32'h0);
        for (int p = a; p <= b; p++) run(8'h01, p);
    endtask

    task automatic t_erase_ranges();
        zero_pages(7, 12);
        run(8'h08, 10);
        chk_page("R6 group below range kept", 7, 32'h0, 32'h0);
        chk_page("R6 group first page erased", 8, 32'hFFFFFFFF, 32'hFFFFFFFF);
        chk_page("R6 group last page erased", 11, 32'hFFFFFFFF, 32'hFFFFFFFF);
        chk_page("R6 group above range kept", 12, 32'h0, 32'h0);
        zero_pages(15, 16); zero_pages(31, 32);
        run(8'h07, 1);
        chk_page("R6 sector below kept", 15, 32'h0, 32'h0);
        chk_page("R6 sector first erased", 16, 32'hFFFFFFFF, 32'hFFFFFFFF);
        chk_page("R6 sector last erased", 31, 32'hFFFFFFFF, 32'hFFFFFFFF);
        chk_page("R6 sector above kept", 32, 32'h0, 32'h0);
        zero_pages(127, 128); zero_pages(255, 255);
        run(8'h06, 1);
        chk_page("R6 plane below kept", 127, 32'h0, 32'h0);
        chk_page("R6 plane first erased", 128, 32'hFFFFFFFF, 32'hFFFFFFFF);
        chk_page("R6 plane last erased", 255, 32'hFFFFFFFF, 32'hFFFFFFFF);
        run(8'h05, 0);
        chk_page("R6 whole array erased", 7, 32'hFFFFFFFF, 32'hFFFFFFFF);
        chk_page("R6 whole array erased", 127, 32'hFFFFFFFF, 32'hFFFFFFFF);
        chk_page("R6 whole array erased", 5, 32'hFFFFFFFF, 32'hFFFFFFFF);
    endtask

    task automatic t_lock();
        logic [31:0] d;
        zero_pages(33, 33);
        run(8'h10, 40);
        run(8'h12, 1);
        reg_read(4'd2, d);
        chk("R8 lock word after set", d, 32'h0000_0100);
        run(8'h01, 40);
        reg_read(4'd1, d);
        chk("R7 locked write sets lock error", d, 32'd5);
        chk_page("R7 locked page unchanged", 40, 32'hFFFFFFFF, 32'hFFFFFFFF);
        fill_buf(32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF);
        run(8'h07, 2);
        reg_read(4'd1, d);
        chk("R7 locked sector erase aborted", d, 32'd5);
        chk_page("R7 sector neighbour not erased", 33, 32'h0, 32'h0);
        run(8'h11, 40);
        reg_read(4'd1, d);
        chk("R12 next command clears lock error", d, 32'd1);
        run(8'h12, 1);
        reg_read(4'd2, d);
        chk("R8 lock word after clear", d, 32'h0);
        zero_pages(40, 40);
        chk_page("R8 unlocked page writable", 40, 32'h0, 32'h0);
    endtask

    task automatic t_gp();
        logic [31:0] d;
        run(8'h20, 2); run(8'h20, 0); run(8'h22, 0);
        reg_read(4'd2, d);
        chk("R9 bits after two sets", d, 32'h5);
        run(8'h21, 2); run(8'h22, 0);
        reg_read(4'd2, d);
        chk("R9 bits after clear", d, 32'h1);
    endtask

    task automatic t_desc();
        logic [31:0] d;
        logic [31:0] exp [9];
        exp = '{32'd4096, 32'd16, 32'd256, 32'd2, 32'd128, 32'd256, 32'd1, 32'd16, 32'd0};
        run(8'h00, 0);
        for (int i = 0; i < 9; i++) begin
            reg_read(4'd2, d);
            chk("R10 descriptor word", d, exp[i]);
        end
    endtask

    task automatic t_reject();
        logic [31:0] d;
        int c0;
        c0 = irq_cnt;
        cmd(8'h7F, 0);
        repeat (3) @(negedge clk);
        reg_read(4'd1, d);
        chk("R11 unknown code rejected", d, 32'd3);
        fill_buf(32'h0, 32'h0, 32'h0, 32'h0);
        cmd(8'h01, 256);
        repeat (3) @(negedge clk);
        reg_read(4'd1, d);
        chk("R11 page out of range rejected", d, 32'd3);
        chk("R11 rejects raise no irq", 32'(irq_cnt - c0), 32'd0);
    endtask

    task automatic t_busy();
        logic [31:0] d;
        int c0;
        run(8'h05, 0);
        fill_buf(32'h0, 32'h0, 32'h0, 32'h0);
        c0 = irq_cnt;
        cmd(8'h05, 0);
        reg_read(4'd1, d);
        chk("R2 ready low while busy", d, 32'd0);
        cmd(8'h01, 3);
        reg_write(4'd8, 32'h1234_5678);
        wait_ready();
        chk("R3 one irq for busy sequence", 32'(irq_cnt - c0), 32'd1);
        reg_read(4'd1, d);
        chk("R2 ignored command leaves no error", d, 32'd1);
        chk_page("R2 command while busy ignored", 3, 32'hFFFFFFFF, 32'hFFFFFFFF);
        run(8'h01, 3);
        chk_page("R2 buffer write while busy ignored", 3, 32'h0, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_keyword();
        t_write_page();
        t_erase_write();
        t_erase_ranges();
        t_lock();
        t_gp();
        t_desc();
        t_reject();
        t_busy();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_vec++; n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule